// File: doc/BRIEF.md
# Duplicate-Tag Coherence Directory

This block tracks which private first-level caches hold a given memory line. It does so by keeping a shadow copy of every core's L1 tag array next to the shared second-level cache. There is one direct-mapped copy per core, held in indexed storage, and the block never does an associative search. A lookup applies the index field of an address to all copies at once. It then compares each selected tag with the address tag. From that it returns three things: which other cores hold the line, whether the requesting core holds it, and the two-bit coherence-policy state stored with the line.

The copies are maintained through one update lane per core. A fill on a lane installs a tag, and an eviction or invalidation on a lane clears the entry. A separate write-back port stores a new policy state into every valid copy of a line. The decision logic that chooses the state sits outside this block.

Lookups are single-cycle and pipelined. A request presented in one cycle produces its result in the next cycle. That result already includes any update made in the request cycle.

Top module: `dup_tag_dir`

## Requirements
- R1: After reset no entry of any copy is valid, so every lookup returns sharers 0, hit 0 and state 0, and `resValid` is low until a lookup is made.
- R2: Address bits [1:0] are a byte offset and are ignored, bits [11:2] select the entry, and bits [31:12] are the tag that must compare equal.
- R3: A lookup accepted with `lkValid` high in cycle N raises `resValid` for exactly cycle N+1, with the results on the outputs; with no lookup, `resValid` is low in the next cycle.
- R4: When `updValid[c]` and `updFill[c]` are both high, the entry of core c selected by `updAddr` lane c becomes valid, takes the tag of that address, and has its state set to 0.
- R5: When `updValid[c]` is high and `updFill[c]` is low, the entry of core c selected by lane c's index becomes invalid, whatever its tag.
- R6: Bit c of `resSharers` is 1 exactly when core c is not the requester and its entry at the lookup index is valid with an equal tag; the requester's own bit is always 0.
- R7: `resHit` is 1 exactly when the requester's own entry at the lookup index is valid with an equal tag.
- R8: `resState` is the stored state of the lowest-numbered core, requester included, whose entry matches; it is 0 when no core matches.
- R9: A `wbValid` strobe writes `wbState` into every core's entry at the index of `wbAddr` that is valid with an equal tag, and changes no other entry.
- R10: Fills, evictions and write-backs made in the same cycle as a lookup are visible in that lookup's result.
- R11: If a fill and a write-back target the same entry in one cycle, the fill wins and the state becomes 0.
- R12: A fill at an index whose entry already holds another tag replaces it, so the old tag no longer matches for that core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request strobe |
| lkAddr | input | 32 | Lookup address |
| lkCore | input | 2 | Requesting core number |
| updValid | input | 4 | Per-core update strobe |
| updFill | input | 4 | Per-core update kind: 1 fill, 0 evict/invalidate |
| updAddr | input | 128 | Per-core update address, lane c in bits [32c+31:32c] |
| wbValid | input | 1 | State write-back strobe |
| wbAddr | input | 32 | Write-back address |
| wbState | input | 2 | State value to store |
| resValid | output | 1 | Lookup result valid |
| resSharers | output | 4 | Other cores holding the line |
| resHit | output | 1 | Requester holds the line |
| resState | output | 2 | Stored policy state of the line |

## Verification
The assertions take for granted that `lkCore` names an existing core and that every strobe is known (0 or 1) once reset is released. They also take for granted that each lane carries at most one operation per cycle, which the port structure forces: a fill and an evict share the same strobe, and `updFill` selects between them. The stimulus draws the requesting core from the four real cores. It builds every address from a chosen tag, index and offset, and in the random phase it uses only a few indices and tags. That narrow range makes tag collisions, same-cycle fill/write-back overlaps and same-cycle update/lookup overlaps occur often.

// File: rtl/dtd_pkg.sv
package dtd_pkg;
  localparam int NUM_CORES = 4;
  localparam int ADDR_W    = 32;
  localparam int OFS_W     = 2;
  localparam int IDX_W     = 10;
  localparam int STATE_W   = 2;
  localparam int TAG_W     = ADDR_W - IDX_W - OFS_W;
  localparam int DEPTH     = 1 << IDX_W;
  localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  typedef logic [IDX_W-1:0]   idx_t;
  typedef logic [TAG_W-1:0]   tag_t;
  typedef logic [STATE_W-1:0] state_t;
  typedef logic [CORE_W-1:0]  core_t;
  typedef logic [ADDR_W-1:0]  addr_t;

  // Strobes from the control half to the storage/compare half.
  typedef struct packed {
    logic                  rdEn;
    idx_t                  rdIdx;
    tag_t                  rdTag;
    core_t                 rdCore;
    logic [NUM_CORES-1:0]  fillEn;
    logic [NUM_CORES-1:0]  clrEn;
    idx_t [NUM_CORES-1:0]  wrIdx;
    tag_t [NUM_CORES-1:0]  wrTag;
    logic                  wbEn;
    idx_t                  wbIdx;
    tag_t                  wbTag;
    state_t                wbState;
  } dtd_strobe_t;

  function automatic idx_t addrIdx(addr_t a);
    return a[OFS_W +: IDX_W];
  endfunction

  function automatic tag_t addrTag(addr_t a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
endpackage

// File: rtl/dtd_ctrl.sv
module dtd_ctrl
  import dtd_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        lkValid,
  input  addr_t                       lkAddr,
  input  core_t                       lkCore,
  input  logic [NUM_CORES-1:0]        updValid,
  input  logic [NUM_CORES-1:0]        updFill,
  input  logic [NUM_CORES*ADDR_W-1:0] updAddr,
  input  logic                        wbValid,
  input  addr_t                       wbAddr,
  input  state_t                      wbState,
  output dtd_strobe_t                 st
);
  // Lookup stage register: index and tag captured in the request cycle.
  logic  rdEnQ;
  idx_t  rdIdxQ;
  tag_t  rdTagQ;
  core_t rdCoreQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdEnQ   <= 1'b0;
      rdIdxQ  <= '0;
      rdTagQ  <= '0;
      rdCoreQ <= '0;
    end else begin
      rdEnQ <= lkValid;
      if (lkValid) begin
        rdIdxQ  <= addrIdx(lkAddr);
        rdTagQ  <= addrTag(lkAddr);
        rdCoreQ <= lkCore;
      end
    end
  end

  // Per-lane decode of the update port.
  idx_t [NUM_CORES-1:0] laneIdx;
  tag_t [NUM_CORES-1:0] laneTag;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_lane
    addr_t laneAddr;
    assign laneAddr   = updAddr[c*ADDR_W +: ADDR_W];
    assign laneIdx[c] = addrIdx(laneAddr);
    assign laneTag[c] = addrTag(laneAddr);
  end

  always_comb begin
    st.rdEn    = rdEnQ;
    st.rdIdx   = rdIdxQ;
    st.rdTag   = rdTagQ;
    st.rdCore  = rdCoreQ;
    st.fillEn  = updValid & updFill;
    st.clrEn   = updValid & ~updFill;
    st.wrIdx   = laneIdx;
    st.wrTag   = laneTag;
    st.wbEn    = wbValid;
    st.wbIdx   = addrIdx(wbAddr);
    st.wbTag   = addrTag(wbAddr);
    st.wbState = wbState;
  end
endmodule

// File: rtl/dtd_datapath.sv
module dtd_datapath
  import dtd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dtd_strobe_t          st,
  output logic                 resValid,
  output logic [NUM_CORES-1:0] resSharers,
  output logic                 resHit,
  output state_t               resState
);
  logic   [NUM_CORES-1:0] rdMatch;
  state_t [NUM_CORES-1:0] rdState;
  logic   [NUM_CORES-1:0] wbMatch;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_copy
    logic [DEPTH-1:0] validQ;
    tag_t             tagMem   [DEPTH];
    state_t           stateMem [DEPTH];
    logic             fillOnWb;

    // Valid bits are the only storage needing reset.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ <= '0;
      end else if (st.fillEn[c]) begin
        validQ[st.wrIdx[c]] <= 1'b1;
      end else if (st.clrEn[c]) begin
        validQ[st.wrIdx[c]] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (st.fillEn[c]) begin
        tagMem[st.wrIdx[c]] <= st.wrTag[c];
      end
    end

    assign wbMatch[c] = st.wbEn && validQ[st.wbIdx] && (tagMem[st.wbIdx] == st.wbTag);
    assign fillOnWb   = st.fillEn[c] && (st.wrIdx[c] == st.wbIdx);

    // Two write paths; a fill on the write-back entry overrides it.
    always_ff @(posedge clk) begin
      if (wbMatch[c] && !fillOnWb) begin
        stateMem[st.wbIdx] <= st.wbState;
      end
      if (st.fillEn[c]) begin
        stateMem[st.wrIdx[c]] <= '0;
      end
    end

    // Read path: entry selected by the registered index.
    assign rdMatch[c] = validQ[st.rdIdx] && (tagMem[st.rdIdx] == st.rdTag);
    assign rdState[c] = stateMem[st.rdIdx];

    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rstN)
      st.fillEn[c] |=> validQ[$past(st.wrIdx[c])]); // R4
    AST_CLR_DROPS_VALID: assert property (@(posedge clk) disable iff (!rstN)
      (st.clrEn[c] && !st.fillEn[c]) |=> !validQ[$past(st.wrIdx[c])]); // R5
    AST_FILL_BEATS_WB: assert property (@(posedge clk) disable iff (!rstN)
      (st.fillEn[c] && st.wbEn && (st.wrIdx[c] == st.wbIdx)) |=> (stateMem[$past(st.wbIdx)] == '0)); // R11
  end

  logic [NUM_CORES-1:0] selfBit;
  state_t               selState;
  logic                 found;

  always_comb begin
    selfBit = '0;
    selfBit[st.rdCore] = 1'b1;
  end

  // Lowest-numbered matching copy supplies the state.
  always_comb begin
    selState = '0;
    found    = 1'b0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (!found && rdMatch[c]) begin
        selState = rdState[c];
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    resValid   = st.rdEn;
    resSharers = st.rdEn ? (rdMatch & ~selfBit) : '0;
    resHit     = st.rdEn && |(rdMatch & selfBit);
    resState   = st.rdEn ? selState : '0;
  end

  AST_NO_SELF_SHARER: assert property (@(posedge clk) disable iff (!rstN)
    st.rdEn |-> !resSharers[st.rdCore]); // R6
  AST_MISS_STATE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdEn && (rdMatch == '0)) |-> (resState == '0)); // R8
endmodule

// File: rtl/dup_tag_dir.sv
module dup_tag_dir
  import dtd_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        lkValid,
  input  logic [ADDR_W-1:0]           lkAddr,
  input  logic [CORE_W-1:0]           lkCore,
  input  logic [NUM_CORES-1:0]        updValid,
  input  logic [NUM_CORES-1:0]        updFill,
  input  logic [NUM_CORES*ADDR_W-1:0] updAddr,
  input  logic                        wbValid,
  input  logic [ADDR_W-1:0]           wbAddr,
  input  logic [STATE_W-1:0]          wbState,
  output logic                        resValid,
  output logic [NUM_CORES-1:0]        resSharers,
  output logic                        resHit,
  output logic [STATE_W-1:0]          resState
);
  dtd_strobe_t st;

  dtd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .lkAddr(lkAddr), .lkCore(lkCore),
    .updValid(updValid), .updFill(updFill), .updAddr(updAddr),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbState(wbState),
    .st(st)
  );

  dtd_datapath dp_i (
    .clk(clk), .rstN(rstN), .st(st),
    .resValid(resValid), .resSharers(resSharers),
    .resHit(resHit), .resState(resState)
  );

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> resValid); // R3
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !resValid); // R3
endmodule

// File: tb/dup_tag_dir_tb_top.sv
`timescale 1ns/1ps
module dup_tag_dir_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         lkValid;
  logic [31:0]  lkAddr;
  logic [1:0]   lkCore;
  logic [3:0]   updValid;
  logic [3:0]   updFill;
  logic [31:0]  uA [4];
  logic [127:0] updAddr;
  logic         wbValid;
  logic [31:0]  wbAddr;
  logic [1:0]   wbState;
  logic         resValid;
  logic [3:0]   resSharers;
  logic         resHit;
  logic [1:0]   resState;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int c = 0; c < 4; c++) updAddr[c*32 +: 32] = uA[c];
  end

  dup_tag_dir dut_i (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .lkAddr(lkAddr), .lkCore(lkCore),
    .updValid(updValid), .updFill(updFill), .updAddr(updAddr),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbState(wbState),
    .resValid(resValid), .resSharers(resSharers),
    .resHit(resHit), .resState(resState)
  );

  // Reference model of the four tag copies.
  bit        mVal   [4][1024];
  bit [19:0] mTag   [4][1024];
  bit [1:0]  mState [4][1024];

  typedef struct {
    bit [3:0] sh;
    bit       hit;
    bit [1:0] st;
    string    tg;
  } exp_t;
  exp_t expQ[$];

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  function automatic logic [31:0] mk(int tag, int idx, int ofs);
    return {tag[19:0], idx[9:0], ofs[1:0]};
  endfunction

  task automatic idleInputs();
    lkValid = 0; lkAddr = '0; lkCore = '0;
    updValid = '0; updFill = '0;
    for (int c = 0; c < 4; c++) uA[c] = '0;
    wbValid = 0; wbAddr = '0; wbState = '0;
  endtask

  // Driver: apply staged inputs to the model, push the expected result, advance.
  task automatic commit(string tg);
    bit wbHitM [4];
    int wi;
    wi = int'(wbAddr[11:2]);
    for (int c = 0; c < 4; c++)
      wbHitM[c] = wbValid && mVal[c][wi] && (mTag[c][wi] == wbAddr[31:12]);
    for (int c = 0; c < 4; c++)
      if (wbHitM[c]) mState[c][wi] = wbState;
    for (int c = 0; c < 4; c++) begin
      if (updValid[c]) begin
        int ui;
        ui = int'(uA[c][11:2]);
        if (updFill[c]) begin
          mVal[c][ui] = 1; mTag[c][ui] = uA[c][31:12]; mState[c][ui] = 0;
        end else begin
          mVal[c][ui] = 0;
        end
      end
    end
    if (lkValid) begin
      exp_t e;
      bit found;
      int li;
      li = int'(lkAddr[11:2]);
      e.sh = '0; e.hit = 0; e.st = '0; e.tg = tg; found = 0;
      for (int c = 0; c < 4; c++) begin
        bit m;
        m = mVal[c][li] && (mTag[c][li] == lkAddr[31:12]);
        if (m && !found) begin e.st = mState[c][li]; found = 1; end
        if (m && c == int'(lkCore)) e.hit = 1;
        else if (m) e.sh[c] = 1;
      end
      expQ.push_back(e);
    end
    @(negedge clk);
    idleInputs();
  endtask

  task automatic look(logic [31:0] a, int core, string tg);
    lkValid = 1; lkAddr = a; lkCore = core[1:0];
    commit(tg);
  endtask

  task automatic fill(int core, logic [31:0] a, string tg);
    updValid[core] = 1; updFill[core] = 1; uA[core] = a;
    commit(tg);
  endtask

  task automatic evict(int core, logic [31:0] a, string tg);
    updValid[core] = 1; updFill[core] = 0; uA[core] = a;
    commit(tg);
  endtask

  task automatic wb(logic [31:0] a, int s, string tg);
    wbValid = 1; wbAddr = a; wbState = s[1:0];
    commit(tg);
  endtask

  // Monitor: one sample per cycle, just after the active edge.
  always @(posedge clk) begin
    if (rstN && !done) begin
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        testCount++;
        if (resValid !== 1'b1) begin
          failCount++;
          $display("FAIL R3 [%s] resValid act=%b exp=1", e.tg, resValid);
        end
        testCount++;
        if (resSharers !== e.sh) begin
          failCount++;
          $display("FAIL R6 [%s] resSharers act=%b exp=%b", e.tg, resSharers, e.sh);
        end
        testCount++;
        if (resHit !== e.hit) begin
          failCount++;
          $display("FAIL R7 [%s] resHit act=%b exp=%b", e.tg, resHit, e.hit);
        end
        testCount++;
        if (resState !== e.st) begin
          failCount++;
          $display("FAIL R8 [%s] resState act=%0d exp=%0d", e.tg, resState, e.st);
        end
      end else begin
        testCount++;
        if (resValid !== 1'b0) begin
          failCount++;
          $display("FAIL R3 idle resValid act=%b exp=0", resValid);
        end
      end
    end
  end

  // Watchdog.
  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      failCount++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [31:0] aA, aB;
    idleInputs();
    aA = mk(5, 7, 0);
    aB = mk(9, 300, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: empty after reset
    look(aA, 0, "R1 reset empty");
    look(mk(0, 0, 0), 1, "R1 reset zero addr");
    look(mk(20'hFFFFF, 1023, 3), 3, "R1 reset top addr");

    // R4 / R6 / R7: single fill
    fill(0, aA, "R4 fill core0");
    look(aA, 1, "R4 R6 other core sees core0");
    look(aA, 0, "R7 own hit, self masked");
    fill(1, aA, "R4 fill core1");
    fill(2, aA, "R4 fill core2");
    look(aA, 3, "R6 three sharers");

    // R2: offset ignored, index and tag fields
    look(mk(5, 7, 3), 3, "R2 offset ignored");
    look(mk(5, 8, 0), 3, "R2 other index");
    look(mk(6, 7, 0), 3, "R2 other tag same index");

    // R9: state write-back
    wb(aA, 2, "R9 write-back state 2");
    look(aA, 3, "R9 state stored");
    wb(mk(6, 7, 0), 3, "R9 write-back tag mismatch");
    look(aA, 3, "R9 mismatch leaves state");

    // R5 / R8: eviction and lowest-core state
    evict(0, mk(31, 7, 0), "R5 evict core0 any tag");
    look(aA, 3, "R5 R8 core0 gone, state from core1");
    fill(0, aA, "R4 refill core0 state 0");
    look(aA, 3, "R8 lowest core state wins");

    // R10: same-cycle update and lookup
    updValid[3] = 1; updFill[3] = 1; uA[3] = aB;
    lkValid = 1; lkAddr = aB; lkCore = 2'd0;
    commit("R10 fill seen by same-cycle lookup");
    updValid[3] = 1; updFill[3] = 0; uA[3] = aB;
    lkValid = 1; lkAddr = aB; lkCore = 2'd1;
    commit("R10 evict seen by same-cycle lookup");
    wbValid = 1; wbAddr = aA; wbState = 2'd1;
    lkValid = 1; lkAddr = aA; lkCore = 2'd3;
    commit("R10 write-back seen by same-cycle lookup");

    // R11: fill beats write-back on one entry
    updValid[1] = 1; updFill[1] = 1; uA[1] = aA;
    wbValid = 1; wbAddr = aA; wbState = 2'd3;
    commit("R11 fill and write-back same entry");
    look(aA, 1, "R11 core1 state 0 own hit");
    evict(0, aA, "R5 evict core0 again");
    look(aA, 3, "R11 lowest match core1 state 0");

    // R12: direct-mapped replacement
    fill(2, mk(77, 7, 0), "R12 replace core2 tag");
    look(aA, 3, "R12 old tag gone for core2");
    look(mk(77, 7, 0), 0, "R12 new tag present");

    // Random phase over few indices and tags.
    for (int n = 0; n < 3000; n++) begin
      int idxSel [4] = '{0, 1, 2, 1023};
      for (int c = 0; c < 4; c++) begin
        if ($urandom_range(0, 3) == 0) begin
          updValid[c] = 1;
          updFill[c]  = ($urandom_range(0, 2) != 0);
          uA[c] = mk($urandom_range(0, 2), idxSel[$urandom_range(0, 3)], $urandom_range(0, 3));
        end
      end
      if ($urandom_range(0, 4) == 0) begin
        wbValid = 1;
        wbAddr  = mk($urandom_range(0, 2), idxSel[$urandom_range(0, 3)], 0);
        wbState = 2'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 2) != 0) begin
        lkValid = 1;
        lkAddr  = mk($urandom_range(0, 2), idxSel[$urandom_range(0, 3)], $urandom_range(0, 3));
        lkCore  = 2'($urandom_range(0, 3));
      end
      commit("R6 R8 R10 random mix");
    end

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule